// File: doc/BRIEF.md
# Software Write-Lock Command Sequencer

This block sits between the bus write decoder and the page write controller of a byte-alterable nonvolatile memory. Every accepted write (address, data and a one-cycle strobe) passes through it. The block decides in the same cycle whether that write may reach the array. It also tracks a software lock, which is driven by fixed command writes.

When the lock is clear, every write goes straight through. Three command writes arm the lock, if it is not already armed, and open one load window. While the window is open, a byte or a whole page can be loaded. The window closes when the page write controller reports that the programming cycle is over, and the lock then guards the array again. A six-write command clears the lock. It first runs a settle interval that models the write-cycle time, and after that interval the array is open again. The lock state after reset is a parameter. One setting models a part as shipped and the other models a part armed before power-down.

A refused write that is not part of a command raises a reject strobe. The page write controller uses that strobe to suppress its completion polling for the rejected write.

Top module: `wrlock_seq`

## Requirements
- R1: After reset, `prot_on` equals the parameter `PROT_INIT`, `load_open` is 0, `settle_busy` is 0, and the command matcher is at its first step.
- R2: While `prot_on` is 0 and `settle_busy` is 0, every write strobe gets `wr_permit` in the same cycle, including writes that form commands.
- R3: While `prot_on` is 1 and `load_open` is 0, no write is permitted. A write that does not advance or complete a command raises `wr_reject` in that cycle. A write that does advance or complete a command raises neither output.
- R4: The unlock command is three writes in order: 0xAA to address 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555. From the cycle after the third write, `load_open` and `prot_on` are both 1. If the third data byte is anything other than 0xA0 or 0x80, no window opens.
- R5: While `load_open` is 1, every write is permitted and none is treated as a command. A `prog_done` pulse in that state closes the window from the next cycle, and `prot_on` stays 1.
- R6: The clear command is six writes in order: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. After the sixth write, `settle_busy` is 1 for `TWC_CYC` cycles. During that time every write is refused with `wr_reject`. When the interval ends, `prot_on` is 0.
- R7: Command addresses are compared on address bits [14:0] only. Bits 15 and 16 do not matter.
- R8: A write that does not match the expected next command word returns the matcher to its first step. That write is not reused as the start of a new command, so a broken command has to be restarted in full.
- R9: An unlock command completed while the lock is clear arms the lock and opens the window. Its third write is itself permitted.
- R10: A `prog_done` pulse while no window is open has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | One-cycle strobe of an accepted write |
| wr_addr | input | AW (17) | Write address |
| wr_data | input | DW (8) | Write data |
| prog_done | input | 1 | Pulse from the page write controller when a programming cycle ends |
| wr_permit | output | 1 | The current write may be stored in the array |
| wr_reject | output | 1 | The current write is refused and is not a command step; polling must not run |
| prot_on | output | 1 | Software lock is armed |
| load_open | output | 1 | One-shot load window is open |
| settle_busy | output | 1 | Lock-clear settle interval is running |

## Verification
The assertions assume that `prog_done` arrives only as a single-cycle pulse. They also assume that `wr_valid`, `wr_addr` and `wr_data` change only between clock edges. The bench drives every input on the falling edge and holds it through the next rising edge. It raises `prog_done` only for one cycle and never in the same cycle as a write. This keeps the stimulus within the assumptions that the window-close and settle properties depend on.

// File: rtl/wrlock_seq_pkg.sv
package wrlock_seq_pkg;

  localparam int unsigned CMD_AW = 15;
  localparam int unsigned CMD_DW = 8;

  localparam logic [CMD_AW-1:0] CMD_ADDR_HI = 15'h5555;
  localparam logic [CMD_AW-1:0] CMD_ADDR_LO = 15'h2AAA;

  localparam logic [CMD_DW-1:0] KEY_FIRST  = 8'hAA;
  localparam logic [CMD_DW-1:0] KEY_SECOND = 8'h55;
  localparam logic [CMD_DW-1:0] KEY_ARM    = 8'hA0;
  localparam logic [CMD_DW-1:0] KEY_EXTEND = 8'h80;
  localparam logic [CMD_DW-1:0] KEY_CLEAR  = 8'h20;

  typedef enum logic [2:0] {
    SEQ_IDLE  = 3'd0,
    SEQ_ONE   = 3'd1,
    SEQ_TWO   = 3'd2,
    SEQ_THREE = 3'd3,
    SEQ_FOUR  = 3'd4,
    SEQ_FIVE  = 3'd5
  } seq_step_e;

  typedef struct packed {
    logic [CMD_AW-1:0] addr;
    logic [CMD_DW-1:0] data;
  } cmd_word_t;

  // Expected command word for a step that has a single continuation.
  function automatic cmd_word_t step_word(input seq_step_e s);
    cmd_word_t w;
    case (s)
      SEQ_IDLE, SEQ_THREE: w = '{addr: CMD_ADDR_HI, data: KEY_FIRST};
      SEQ_ONE,  SEQ_FOUR:  w = '{addr: CMD_ADDR_LO, data: KEY_SECOND};
      SEQ_FIVE:            w = '{addr: CMD_ADDR_HI, data: KEY_CLEAR};
      default:             w = '{addr: CMD_ADDR_HI, data: KEY_ARM};
    endcase
    return w;
  endfunction

  // Masked compare: only the low CMD_AW address bits take part.
  function automatic logic word_hit(input logic [CMD_AW-1:0] addr_low,
                                    input logic [CMD_DW-1:0] data,
                                    input cmd_word_t         w);
    return (addr_low == w.addr) && (data == w.data);
  endfunction

  function automatic seq_step_e step_next(input seq_step_e s);
    seq_step_e n;
    case (s)
      SEQ_IDLE:  n = SEQ_ONE;
      SEQ_ONE:   n = SEQ_TWO;
      SEQ_THREE: n = SEQ_FOUR;
      SEQ_FOUR:  n = SEQ_FIVE;
      default:   n = SEQ_IDLE;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/wrlock_seq_matcher.sv
module wrlock_seq_matcher
  import wrlock_seq_pkg::*;
#(
  parameter int unsigned AW = 17,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          match_en,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          cmd_step,
  output logic          unlock_hit,
  output logic          disable_hit,
  output seq_step_e     step_q
);

  localparam logic [AW-1:0] LOW_MASK = {{(AW-CMD_AW){1'b0}}, {CMD_AW{1'b1}}};

  logic [AW-1:0]     masked_addr;
  logic [CMD_AW-1:0] addr_low;
  logic              take;
  logic              hit_plain;
  logic              hit_arm;
  logic              hit_ext;
  seq_step_e         step_d;

  assign masked_addr = wr_addr & LOW_MASK;
  assign addr_low    = masked_addr[CMD_AW-1:0];
  assign take        = match_en && wr_valid;

  assign hit_plain = word_hit(addr_low, wr_data[CMD_DW-1:0], step_word(step_q));
  assign hit_arm   = word_hit(addr_low, wr_data[CMD_DW-1:0],
                              '{addr: CMD_ADDR_HI, data: KEY_ARM});
  assign hit_ext   = word_hit(addr_low, wr_data[CMD_DW-1:0],
                              '{addr: CMD_ADDR_HI, data: KEY_EXTEND});

  always_comb begin
    step_d      = step_q;
    cmd_step    = 1'b0;
    unlock_hit  = 1'b0;
    disable_hit = 1'b0;
    if (take) begin
      step_d = SEQ_IDLE;
      case (step_q)
        SEQ_TWO: begin
          if (hit_arm) begin
            cmd_step   = 1'b1;
            unlock_hit = 1'b1;
          end else if (hit_ext) begin
            cmd_step = 1'b1;
            step_d   = SEQ_THREE;
          end
        end
        SEQ_FIVE: begin
          if (hit_plain) begin
            cmd_step    = 1'b1;
            disable_hit = 1'b1;
          end
        end
        default: begin
          if (hit_plain) begin
            cmd_step = 1'b1;
            step_d   = step_next(step_q);
          end
        end
      endcase
    end else if (!match_en) begin
      step_d = SEQ_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) step_q <= SEQ_IDLE;
    else        step_q <= step_d;
  end

endmodule

// File: rtl/wrlock_seq_lock.sv
module wrlock_seq_lock #(
  parameter int unsigned TWC_CYC   = 20,
  parameter bit          PROT_INIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic unlock_hit,
  input  logic disable_hit,
  input  logic prog_done,
  output logic prot_on,
  output logic load_open,
  output logic settle_busy
);

  localparam int unsigned CW = $clog2(TWC_CYC + 1);
  localparam logic [CW-1:0] SETTLE_LOAD = CW'(TWC_CYC);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(1);

  logic [CW-1:0] settle_cnt;
  logic          settle_end;

  assign settle_busy = (settle_cnt != '0);
  assign settle_end  = (settle_cnt == SETTLE_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      settle_cnt <= '0;
    end else if (disable_hit) begin
      settle_cnt <= SETTLE_LOAD;
    end else if (settle_busy) begin
      settle_cnt <= settle_cnt - SETTLE_LAST;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prot_on   <= PROT_INIT;
      load_open <= 1'b0;
    end else begin
      if (unlock_hit) begin
        prot_on   <= 1'b1;
        load_open <= 1'b1;
      end else begin
        if (settle_end) prot_on <= 1'b0;
        if (load_open && prog_done) load_open <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/wrlock_seq_gate.sv
module wrlock_seq_gate (
  input  logic wr_valid,
  input  logic prot_on,
  input  logic load_open,
  input  logic settle_busy,
  input  logic cmd_step,
  output logic match_en,
  output logic wr_permit,
  output logic wr_reject
);

  logic path_open;

  assign match_en  = !load_open && !settle_busy;
  assign path_open = !settle_busy && (!prot_on || load_open);
  assign wr_permit = wr_valid && path_open;
  assign wr_reject = wr_valid && !path_open && !cmd_step;

endmodule

// File: rtl/wrlock_seq.sv
module wrlock_seq
  import wrlock_seq_pkg::*;
#(
  parameter int unsigned AW        = 17,
  parameter int unsigned DW        = 8,
  parameter int unsigned TWC_CYC   = 20,
  parameter bit          PROT_INIT = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          prog_done,
  output logic          wr_permit,
  output logic          wr_reject,
  output logic          prot_on,
  output logic          load_open,
  output logic          settle_busy
);

  logic      match_en;
  logic      cmd_step;
  logic      unlock_hit;
  logic      disable_hit;
  seq_step_e seq_step;

  wrlock_seq_matcher #(.AW(AW), .DW(DW)) u_match (
    .clk        (clk),
    .rst_n      (rst_n),
    .match_en   (match_en),
    .wr_valid   (wr_valid),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .cmd_step   (cmd_step),
    .unlock_hit (unlock_hit),
    .disable_hit(disable_hit),
    .step_q     (seq_step)
  );

  wrlock_seq_lock #(.TWC_CYC(TWC_CYC), .PROT_INIT(PROT_INIT)) u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .unlock_hit (unlock_hit),
    .disable_hit(disable_hit),
    .prog_done  (prog_done),
    .prot_on    (prot_on),
    .load_open  (load_open),
    .settle_busy(settle_busy)
  );

  wrlock_seq_gate u_gate (
    .wr_valid   (wr_valid),
    .prot_on    (prot_on),
    .load_open  (load_open),
    .settle_busy(settle_busy),
    .cmd_step   (cmd_step),
    .match_en   (match_en),
    .wr_permit  (wr_permit),
    .wr_reject  (wr_reject)
  );

endmodule

// File: rtl/wrlock_seq_chk.sv
module wrlock_seq_chk
  import wrlock_seq_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      wr_valid,
  input logic      prog_done,
  input logic      wr_permit,
  input logic      wr_reject,
  input logic      prot_on,
  input logic      load_open,
  input logic      settle_busy,
  input logic      cmd_step,
  input logic      unlock_hit,
  input logic      disable_hit,
  input seq_step_e seq_step
);

  AST_WINDOW_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    load_open |-> prot_on);                                           // R4
  AST_UNLOCK_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_hit |=> (load_open && prot_on));                           // R4
  AST_LOCKED_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_on && !load_open) |-> !wr_permit);                          // R3
  AST_OPEN_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (!prot_on && !settle_busy && wr_valid) |-> wr_permit);            // R2
  AST_WINDOW_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    load_open |-> (!cmd_step && seq_step == SEQ_IDLE));               // R5
  AST_WINDOW_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (load_open && prog_done) |=> (!load_open && prot_on));            // R5
  AST_SETTLE_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    settle_busy |-> !wr_permit);                                      // R6
  AST_CLEAR_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    disable_hit |=> settle_busy);                                     // R6
  AST_SETTLE_ENDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(settle_busy) |-> !prot_on);                                 // R6
  AST_ARM_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_on) |-> $past(unlock_hit));                            // R9
  AST_IDLE_DONE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_done && !load_open && !unlock_hit && !settle_busy && !disable_hit)
      |=> ($stable(prot_on) && !load_open));                          // R10

endmodule

bind wrlock_seq wrlock_seq_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid   (wr_valid),
  .prog_done  (prog_done),
  .wr_permit  (wr_permit),
  .wr_reject  (wr_reject),
  .prot_on    (prot_on),
  .load_open  (load_open),
  .settle_busy(settle_busy),
  .cmd_step   (cmd_step),
  .unlock_hit (unlock_hit),
  .disable_hit(disable_hit),
  .seq_step   (seq_step)
);

// File: tb/test_wrlock_seq.sv
module test_wrlock_seq;

  localparam int TWC = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [16:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        prog_done = 1'b0;
  logic        wr_permit, wr_reject, prot_on, load_open, settle_busy;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  // Bench-side expectation state, built from the requirements.
  bit m_prot = 1'b0;
  bit m_win  = 1'b0;
  int m_cnt  = 0;
  int m_step = 0;

  always #5 clk = ~clk;

  wrlock_seq #(.AW(17), .DW(8), .TWC_CYC(TWC), .PROT_INIT(1'b0)) i_wrlock_seq (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .prog_done(prog_done), .wr_permit(wr_permit),
    .wr_reject(wr_reject), .prot_on(prot_on), .load_open(load_open),
    .settle_busy(settle_busy)
  );

  task automatic chk(input logic got, input logic exp, input string tag, input string what);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, got, exp, $time);
    end
  endtask

  // Command word expected at each matcher step (step 2 has two branches).
  function automatic bit word_is(input int s, input logic [16:0] a, input logic [7:0] d);
    logic [14:0] lo;
    lo = a[14:0];
    case (s)
      0, 3:    return lo == 15'h5555 && d == 8'hAA;
      1, 4:    return lo == 15'h2AAA && d == 8'h55;
      5:       return lo == 15'h5555 && d == 8'h20;
      default: return 1'b0;
    endcase
  endfunction

  task automatic cyc(input logic v, input logic [16:0] a, input logic [7:0] d,
                     input logic dn, input string tag);
    bit active, adv, unl, dis, e_perm, e_rej;
    int nstep;
    @(negedge clk);
    wr_valid = v; wr_addr = a; wr_data = d; prog_done = dn;
    #1;
    active = !m_win && (m_cnt == 0);
    adv = 0; unl = 0; dis = 0; nstep = m_step;
    if (!active) nstep = 0;
    else if (v) begin
      nstep = 0;
      if (m_step == 2) begin
        if (a[14:0] == 15'h5555 && d == 8'hA0) begin adv = 1; unl = 1; end
        else if (a[14:0] == 15'h5555 && d == 8'h80) begin adv = 1; nstep = 3; end
      end else if (word_is(m_step, a, d)) begin
        adv = 1;
        if (m_step == 5) dis = 1; else nstep = m_step + 1;
      end
    end
    e_perm = v && (m_cnt == 0) && (!m_prot || m_win);
    e_rej  = v && !e_perm && !adv;
    chk(wr_permit,   e_perm,        tag, "wr_permit");
    chk(wr_reject,   e_rej,         tag, "wr_reject");
    chk(prot_on,     m_prot,        tag, "prot_on");
    chk(load_open,   m_win,         tag, "load_open");
    chk(settle_busy, (m_cnt != 0),  tag, "settle_busy");
    @(posedge clk);
    if (dis) m_cnt = TWC;
    else if (m_cnt > 0) begin
      if (m_cnt == 1) m_prot = 0;
      m_cnt--;
    end
    if (unl) begin m_prot = 1; m_win = 1; end
    else if (m_win && dn) m_win = 0;
    m_step = nstep;
  endtask

  task automatic idle(input string tag);
    cyc(1'b0, 17'h0, 8'h00, 1'b0, tag);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    idle("R1");

    // Open access: plain and command-looking writes all pass (R2)
    cyc(1, 17'h00000, 8'h11, 0, "R2");
    cyc(1, 17'h1FFFF, 8'hFF, 0, "R2");
    cyc(1, 17'h05555, 8'hAA, 0, "R2");
    cyc(1, 17'h00123, 8'h42, 0, "R2");
    cyc(0, 17'h0, 8'h0, 1, "R10");
    idle("R10");

    // Arm from open mode; third command write itself permitted (R9)
    cyc(1, 17'h05555, 8'hAA, 0, "R9");
    cyc(1, 17'h02AAA, 8'h55, 0, "R9");
    cyc(1, 17'h05555, 8'hA0, 0, "R9");
    idle("R9");

    // Window writes, including command words, then close (R5)
    cyc(1, 17'h00300, 8'h01, 0, "R5");
    cyc(1, 17'h05555, 8'hAA, 0, "R5");
    cyc(1, 17'h02AAA, 8'h55, 0, "R5");
    cyc(1, 17'h05555, 8'h80, 0, "R5");
    cyc(0, 17'h0, 8'h0, 1, "R5");
    idle("R5");

    // Locked: plain writes rejected, command steps absorbed (R3)
    cyc(1, 17'h00400, 8'h33, 0, "R3");
    cyc(1, 17'h05555, 8'hAA, 0, "R3");
    cyc(1, 17'h00401, 8'h34, 0, "R3");
    cyc(0, 17'h0, 8'h0, 1, "R10");
    idle("R10");

    // Broken command must restart in full (R8)
    cyc(1, 17'h05555, 8'hAA, 0, "R8");
    cyc(1, 17'h02AAA, 8'h55, 0, "R8");
    cyc(1, 17'h05555, 8'hAA, 0, "R8");
    cyc(1, 17'h02AAA, 8'h55, 0, "R8");
    cyc(1, 17'h05555, 8'hA0, 0, "R8");
    idle("R8");

    // Upper address bits do not matter (R7)
    cyc(1, 17'h15555, 8'hAA, 0, "R7");
    cyc(1, 17'h0AAAA, 8'h55, 0, "R7");
    cyc(1, 17'h1D555, 8'hA0, 0, "R7");
    cyc(1, 17'h00500, 8'h77, 0, "R7");
    cyc(0, 17'h0, 8'h0, 1, "R7");
    idle("R7");

    // Sweep every third-step data byte while locked (R4)
    for (int dv = 0; dv < 256; dv++) begin
      cyc(1, 17'h05555, 8'hAA, 0, "R4");
      cyc(1, 17'h02AAA, 8'h55, 0, "R4");
      cyc(1, 17'h05555, dv[7:0], 0, "R4");
      idle("R4");
      if (dv == 8'hA0) begin
        cyc(1, 17'h00600, 8'h5A, 0, "R5");
        cyc(0, 17'h0, 8'h0, 1, "R5");
      end else if (dv == 8'h80) begin
        cyc(1, 17'h00000, 8'h00, 0, "R8");
      end
    end

    // Clear command, settle interval, then open again (R6)
    cyc(1, 17'h05555, 8'hAA, 0, "R6");
    cyc(1, 17'h12AAA, 8'h55, 0, "R6");
    cyc(1, 17'h05555, 8'h80, 0, "R6");
    cyc(1, 17'h0D555, 8'hAA, 0, "R6");
    cyc(1, 17'h02AAA, 8'h55, 0, "R6");
    cyc(1, 17'h05555, 8'h20, 0, "R6");
    for (int k = 0; k < TWC + 2; k++) cyc(1, 17'h00042, k[7:0], 0, "R6");
    cyc(1, 17'h00043, 8'h99, 0, "R2");
    cyc(1, 17'h05555, 8'hAA, 0, "R2");
    idle("R2");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule